// File: doc/BRIEF.md
# Redo Log Commit and Recovery Sequencer

This block sits between the last cache level and a non-volatile main memory. Speculative lines that a transaction pushes out toward non-volatile memory are not written to their home locations. Each one becomes a record in a circular redo log, tagged with the owning transaction number, the home address and the line data. A transaction ends with a single log entry: either a commit mark or an abort mark. That one entry is the atomic point at which the outcome becomes durable.

While the foreground is quiet, a background copier takes the oldest log entry. It writes committed data home, drops aborted data and retires marks. It never moves past a record whose transaction has not yet been marked. A read that missed the upstream DRAM cache comes through the lookup port. The sequencer first searches the log from the newest entry back to the oldest and returns the first live match. Only when nothing matches does it read the home location.

After a power loss the recovery handshake throws away the volatile per-transaction status and rebuilds it in two passes. The first pass collects every commit and abort mark into a status table. The second pass writes back, in log order, only the data records of transactions that were found committed. Records of transactions that carry no mark are treated as aborted. The log is left empty.

Top module: `nvm_redo_log_seq`

## Requirements
- R1: After reset the log is empty. `ap_ready`, `cmd_ready` and `rd_ready` are 1 when no request is present, and `rd_valid`, `rec_done`, `mem_we` and `mem_re` are 0.
- R2: An append is taken in a cycle where `ap_valid` and `ap_ready` are both 1. It adds one data record (transaction number, home address, data) at the tail and raises the occupancy by one.
- R3: A command is taken when `cmd_valid` and `cmd_ready` are both 1. It adds exactly one mark entry: a commit mark when `cmd_abort` is 0, an abort mark when it is 1. When an append and a command arrive together, the append goes first.
- R4: A lookup scans the log from the newest entry toward the oldest. It answers with the newest data record at the requested address whose transaction is not aborted, with `rd_from_log`=1. The answer is a `rd_valid` pulse of exactly one cycle.
- R5: A lookup that finds no live record reads the home location through the memory port. It answers with that word and `rd_from_log`=0.
- R6: Data records of an aborted transaction are never returned by a lookup and never written home.
- R7: When no foreground request is pending, the oldest entry is processed. A committed data record is written to its home address, an aborted one is dropped, and a mark is retired. Committed data therefore reaches home in log order.
- R8: Background processing stops at a data record whose transaction has no mark yet. Nothing behind it is written home until that transaction is marked.
- R9: Data appends are refused once the log holds DEPTH-1 entries, so a mark can always be taken up to DEPTH entries. Refused appends are taken as soon as background processing frees space.
- R10: A recovery started with `rec_start` rebuilds transaction status only from marks in the log. It then writes the committed data records home in log order, empties the log and ends with a one-cycle `rec_done` pulse.
- R11: During recovery, records of transactions with neither mark are skipped.
- R12: While a lookup or recovery is running, `ap_ready`, `cmd_ready` and `rd_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ap_valid | input | 1 | Append request for a data record |
| ap_ready | output | 1 | Append can be taken this cycle |
| ap_txid | input | TXID_W | Owning transaction number |
| ap_addr | input | ADDR_W | Home address of the line |
| ap_data | input | DATA_W | Line data |
| cmd_valid | input | 1 | Commit or abort request |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_abort | input | 1 | 1 writes an abort mark, 0 a commit mark |
| cmd_txid | input | TXID_W | Transaction being marked |
| rd_req | input | 1 | Lookup request |
| rd_ready | output | 1 | Lookup can be taken this cycle |
| rd_addr | input | ADDR_W | Address to look up |
| rd_valid | output | 1 | Lookup answer pulse |
| rd_data | output | DATA_W | Lookup answer data |
| rd_from_log | output | 1 | Answer came from the log |
| rec_start | input | 1 | Start recovery |
| rec_done | output | 1 | Recovery finished pulse |
| mem_we | output | 1 | Home memory write |
| mem_re | output | 1 | Home memory read, data one cycle later |
| mem_addr | output | ADDR_W | Home memory address |
| mem_wdata | output | DATA_W | Home memory write data |
| mem_rdata | input | DATA_W | Home memory read data |

## Verification
The lookup function is exercised against a log that holds two versions of one address from an open transaction, a record of another open transaction, and a record of an aborted transaction. Addresses absent from the log are also looked up. This separates newest-wins ordering, the rule that aborted records are skipped, and the fallback to home memory. Background copying is tested with an unmarked transaction at the head, which must block everything behind it. It is then tested with a full log of one transaction whose commit mark only fits thanks to the reserved slot. Recovery is run on a log that mixes committed, aborted and unmarked transactions with a repeated address, which shows both the mark-only status rebuild and the log-order write-back.

// File: rtl/nvm_redo_pkg.sv
package nvm_redo_pkg;

    typedef enum logic [1:0] {
        REC_DATA   = 2'd0,
        REC_COMMIT = 2'd1,
        REC_ABORT  = 2'd2
    } rec_kind_e;

    typedef enum logic [1:0] {
        TX_OPEN      = 2'd0,
        TX_COMMITTED = 2'd1,
        TX_ABORTED   = 2'd2
    } tx_status_e;

    typedef enum logic [2:0] {
        SEQ_IDLE     = 3'd0,
        SEQ_LOOK     = 3'd1,
        SEQ_LOOK_MEM = 3'd2,
        SEQ_SCAN     = 3'd3,
        SEQ_REPLAY   = 3'd4
    } seq_state_e;

endpackage

// File: rtl/redo_log_store.sv
module redo_log_store #(
    parameter int DEPTH = 64,
    parameter int W     = 48,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [W-1:0]     wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [W-1:0]     rdata
);

    logic [W-1:0] slot_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            slot_q[widx] <= wdata;
        end
    end

    assign rdata = slot_q[ridx];

endmodule

// File: rtl/redo_txn_table.sv
module redo_txn_table
    import nvm_redo_pkg::*;
#(
    parameter int TXID_W = 4,
    localparam int NTX = 1 << TXID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [TXID_W-1:0] set_tx,
    input  tx_status_e        set_st,
    input  logic              clr_en,
    input  logic [TXID_W-1:0] clr_tx,
    input  logic              clr_all,
    input  logic [TXID_W-1:0] rd_tx,
    output tx_status_e        rd_st
);

    tx_status_e st_q [NTX];

    for (genvar t = 0; t < NTX; t++) begin : g_slot
        tx_status_e st_d;

        always_comb begin
            st_d = st_q[t];
            if (clr_all) begin
                st_d = TX_OPEN;
            end else if (set_en && set_tx == TXID_W'(t)) begin
                st_d = set_st;
            end else if (clr_en && clr_tx == TXID_W'(t)) begin
                st_d = TX_OPEN;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q[t] <= TX_OPEN;
            end else begin
                st_q[t] <= st_d;
            end
        end
    end

    assign rd_st = st_q[rd_tx];

endmodule

// File: rtl/nvm_redo_log_seq.sv
module nvm_redo_log_seq
    import nvm_redo_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 32,
    parameter int TXID_W    = 4,
    parameter int LOG_DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ap_valid,
    output logic              ap_ready,
    input  logic [TXID_W-1:0] ap_txid,
    input  logic [ADDR_W-1:0] ap_addr,
    input  logic [DATA_W-1:0] ap_data,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_abort,
    input  logic [TXID_W-1:0] cmd_txid,
    input  logic              rd_req,
    output logic              rd_ready,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_from_log,
    input  logic              rec_start,
    output logic              rec_done,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int IDX_W = $clog2(LOG_DEPTH);
    localparam int CNT_W = IDX_W + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(LOG_DEPTH);
    localparam logic [CNT_W-1:0] DATA_LIM = CNT_W'(LOG_DEPTH - 1);
    localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);
    localparam logic [IDX_W-1:0] ONE_IDX  = IDX_W'(1);

    typedef struct packed {
        rec_kind_e         kind;
        logic [TXID_W-1:0] txid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } rec_t;

    localparam int REC_W = $bits(rec_t);

    typedef struct packed {
        seq_state_e        st;
        logic [IDX_W-1:0]  head;
        logic [IDX_W-1:0]  tail;
        logic [IDX_W-1:0]  idx;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  rem;
        logic [ADDR_W-1:0] key;
        logic              rd_valid;
        logic [DATA_W-1:0] rd_data;
        logic              rd_from_log;
        logic              rec_done;
    } ctrl_t;

    ctrl_t q, d;

    // log storage and transaction status
    logic              log_we;
    rec_t              log_wrec;
    logic [IDX_W-1:0]  log_ridx;
    logic [REC_W-1:0]  log_rdata;
    rec_t              cur;

    logic              tbl_set;
    logic [TXID_W-1:0] tbl_set_tx;
    tx_status_e        tbl_set_st;
    logic              tbl_clr;
    logic [TXID_W-1:0] tbl_clr_tx;
    logic              tbl_clr_all;
    tx_status_e        cur_st;

    assign log_ridx = (q.st == SEQ_IDLE) ? q.head : q.idx;
    assign cur      = rec_t'(log_rdata);

    redo_log_store #(
        .DEPTH (LOG_DEPTH),
        .W     (REC_W)
    ) u_store (
        .clk   (clk),
        .we    (log_we),
        .widx  (q.tail),
        .wdata (log_wrec),
        .ridx  (log_ridx),
        .rdata (log_rdata)
    );

    redo_txn_table #(
        .TXID_W (TXID_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (tbl_set),
        .set_tx  (tbl_set_tx),
        .set_st  (tbl_set_st),
        .clr_en  (tbl_clr),
        .clr_tx  (tbl_clr_tx),
        .clr_all (tbl_clr_all),
        .rd_tx   (cur.txid),
        .rd_st   (cur_st)
    );

    // admission: recovery first, then lookup, then append, then command
    logic seq_idle, data_room, mark_room, ap_fire, cmd_fire;

    assign seq_idle  = (q.st == SEQ_IDLE);
    assign data_room = (q.cnt < DATA_LIM);
    assign mark_room = (q.cnt < FULL_CNT);
    assign rd_ready  = seq_idle && !rec_start;
    assign ap_ready  = rd_ready && !rd_req && data_room;
    assign cmd_ready = rd_ready && !rd_req && !(ap_valid && data_room) && mark_room;
    assign ap_fire   = ap_valid && ap_ready;
    assign cmd_fire  = cmd_valid && cmd_ready;

    always_comb begin
        logic pop;
        pop         = 1'b0;
        d           = q;
        d.rd_valid  = 1'b0;
        d.rec_done  = 1'b0;
        log_we      = 1'b0;
        log_wrec    = '0;
        tbl_set     = 1'b0;
        tbl_set_tx  = '0;
        tbl_set_st  = TX_OPEN;
        tbl_clr     = 1'b0;
        tbl_clr_tx  = '0;
        tbl_clr_all = 1'b0;
        mem_we      = 1'b0;
        mem_re      = 1'b0;
        mem_addr    = '0;
        mem_wdata   = '0;

        unique case (q.st)
            SEQ_IDLE: begin
                if (rec_start) begin
                    // volatile status is lost: rebuild it from marks only
                    tbl_clr_all = 1'b1;
                    d.idx       = q.head;
                    d.rem       = q.cnt;
                    d.st        = SEQ_SCAN;
                end else if (rd_req) begin
                    d.idx = q.tail - ONE_IDX;
                    d.rem = q.cnt;
                    d.key = rd_addr;
                    d.st  = SEQ_LOOK;
                end else if (ap_fire) begin
                    log_we        = 1'b1;
                    log_wrec.kind = REC_DATA;
                    log_wrec.txid = ap_txid;
                    log_wrec.addr = ap_addr;
                    log_wrec.data = ap_data;
                    d.tail        = q.tail + ONE_IDX;
                    d.cnt         = q.cnt + ONE_CNT;
                end else if (cmd_fire) begin
                    log_we        = 1'b1;
                    log_wrec.kind = cmd_abort ? REC_ABORT : REC_COMMIT;
                    log_wrec.txid = cmd_txid;
                    tbl_set       = 1'b1;
                    tbl_set_tx    = cmd_txid;
                    tbl_set_st    = cmd_abort ? TX_ABORTED : TX_COMMITTED;
                    d.tail        = q.tail + ONE_IDX;
                    d.cnt         = q.cnt + ONE_CNT;
                end else if (q.cnt != '0) begin
                    // background copy of the oldest entry
                    if (cur.kind == REC_DATA) begin
                        if (cur_st == TX_COMMITTED) begin
                            mem_we    = 1'b1;
                            mem_addr  = cur.addr;
                            mem_wdata = cur.data;
                            pop       = 1'b1;
                        end else if (cur_st == TX_ABORTED) begin
                            pop = 1'b1;
                        end
                    end else begin
                        tbl_clr    = 1'b1;
                        tbl_clr_tx = cur.txid;
                        pop        = 1'b1;
                    end
                    if (pop) begin
                        d.head = q.head + ONE_IDX;
                        d.cnt  = q.cnt - ONE_CNT;
                    end
                end
            end

            SEQ_LOOK: begin
                if (q.rem == '0) begin
                    mem_re   = 1'b1;
                    mem_addr = q.key;
                    d.st     = SEQ_LOOK_MEM;
                end else if (cur.kind == REC_DATA && cur.addr == q.key &&
                             cur_st != TX_ABORTED) begin
                    d.rd_valid    = 1'b1;
                    d.rd_data     = cur.data;
                    d.rd_from_log = 1'b1;
                    d.st          = SEQ_IDLE;
                end else begin
                    d.idx = q.idx - ONE_IDX;
                    d.rem = q.rem - ONE_CNT;
                end
            end

            SEQ_LOOK_MEM: begin
                d.rd_valid    = 1'b1;
                d.rd_data     = mem_rdata;
                d.rd_from_log = 1'b0;
                d.st          = SEQ_IDLE;
            end

            SEQ_SCAN: begin
                if (q.rem == '0) begin
                    d.idx = q.head;
                    d.rem = q.cnt;
                    d.st  = SEQ_REPLAY;
                end else begin
                    if (cur.kind == REC_COMMIT || cur.kind == REC_ABORT) begin
                        tbl_set    = 1'b1;
                        tbl_set_tx = cur.txid;
                        tbl_set_st = (cur.kind == REC_COMMIT) ? TX_COMMITTED : TX_ABORTED;
                    end
                    d.idx = q.idx + ONE_IDX;
                    d.rem = q.rem - ONE_CNT;
                end
            end

            SEQ_REPLAY: begin
                if (q.rem == '0) begin
                    tbl_clr_all = 1'b1;
                    d.head      = q.tail;
                    d.cnt       = '0;
                    d.rec_done  = 1'b1;
                    d.st        = SEQ_IDLE;
                end else begin
                    if (cur.kind == REC_DATA && cur_st == TX_COMMITTED) begin
                        mem_we    = 1'b1;
                        mem_addr  = cur.addr;
                        mem_wdata = cur.data;
                    end
                    d.idx = q.idx + ONE_IDX;
                    d.rem = q.rem - ONE_CNT;
                end
            end

            default: d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= SEQ_IDLE;
        end else begin
            q <= d;
        end
    end

    assign rd_valid    = q.rd_valid;
    assign rd_data     = q.rd_data;
    assign rd_from_log = q.rd_from_log;
    assign rec_done    = q.rec_done;

    // observation points for the bound checker
    logic [CNT_W-1:0] occ;
    seq_state_e       cur_state;
    assign occ       = q.cnt;
    assign cur_state = q.st;

endmodule

// File: rtl/nvm_redo_log_seq_chk.sv
module nvm_redo_log_seq_chk
    import nvm_redo_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ap_fire,
    input logic             cmd_fire,
    input logic             ap_ready,
    input logic             rd_valid,
    input logic             rec_done,
    input logic             mem_we,
    input logic [CNT_W-1:0] occ,
    input seq_state_e       st,
    input tx_status_e       head_st
);

    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

    assert_occ_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= DEPTH_C);

    assert_append_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ap_fire |=> occ == $past(occ) + ONE_C);

    assert_mark_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fire |=> occ == $past(occ) + ONE_C);

    assert_no_open_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && st == SEQ_IDLE) |-> head_st == TX_COMMITTED);

    assert_rd_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_rec_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rec_done |-> occ == '0);

    assert_busy_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st != SEQ_IDLE) |-> !ap_ready);

endmodule

bind nvm_redo_log_seq nvm_redo_log_seq_chk #(
    .DEPTH (LOG_DEPTH),
    .CNT_W (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ap_fire  (ap_fire),
    .cmd_fire (cmd_fire),
    .ap_ready (ap_ready),
    .rd_valid (rd_valid),
    .rec_done (rec_done),
    .mem_we   (mem_we),
    .occ      (occ),
    .st       (cur_state),
    .head_st  (cur_st)
);

// File: tb/test_nvm_redo_log_seq.sv
`timescale 1ns/1ps
module test_nvm_redo_log_seq;

    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;
    localparam int TXID_W = 4;
    localparam int DEPTH  = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic              ap_valid = 0, ap_ready;
    logic [TXID_W-1:0] ap_txid = '0;
    logic [ADDR_W-1:0] ap_addr = '0;
    logic [DATA_W-1:0] ap_data = '0;
    logic              cmd_valid = 0, cmd_ready, cmd_abort = 0;
    logic [TXID_W-1:0] cmd_txid = '0;
    logic              rd_req = 0, rd_ready, rd_valid, rd_from_log;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic              rec_start = 0, rec_done;
    logic              mem_we, mem_re;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;

    nvm_redo_log_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TXID_W(TXID_W), .LOG_DEPTH(DEPTH)
    ) i_nvm_redo_log_seq (
        .clk(clk), .rst_n(rst_n),
        .ap_valid(ap_valid), .ap_ready(ap_ready), .ap_txid(ap_txid),
        .ap_addr(ap_addr), .ap_data(ap_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_abort(cmd_abort),
        .cmd_txid(cmd_txid),
        .rd_req(rd_req), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_from_log(rd_from_log),
        .rec_start(rec_start), .rec_done(rec_done),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // behavioural non-volatile array
    logic [DATA_W-1:0] nvm [1 << ADDR_W];
    always @(posedge clk) begin
        if (mem_we) nvm[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= nvm[mem_addr];
    end

    function automatic logic [DATA_W-1:0] home(input int a);
        return 32'hC0DE_0000 | DATA_W'(a);
    endfunction

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    task automatic chk(input string req, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic append(input int tx, input int a, input int dat);
        @(negedge clk);
        ap_valid = 1; ap_txid = TXID_W'(tx); ap_addr = ADDR_W'(a); ap_data = DATA_W'(dat);
        #1;
        while (!ap_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        ap_valid = 0;
    endtask

    task automatic mark(input int tx, input bit abrt);
        @(negedge clk);
        cmd_valid = 1; cmd_txid = TXID_W'(tx); cmd_abort = abrt;
        #1;
        while (!cmd_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic lookup(input int a, output logic [DATA_W-1:0] dat, output logic fl);
        int n;
        @(negedge clk);
        rd_req = 1; rd_addr = ADDR_W'(a);
        #1;
        while (!rd_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        rd_req = 0;
        n = 0;
        while (!rd_valid && n < 500) begin @(negedge clk); n++; end
        dat = rd_data;
        fl  = rd_from_log;
    endtask

    // lookup table: address, expected data, expected from-log flag
    localparam int NV = 5;
    localparam logic [ADDR_W+DATA_W:0] VEC [NV] = '{
        {10'h010, 32'h0000_0222, 1'b1},   // R4 newest of two versions
        {10'h020, 32'h0000_0333, 1'b1},   // R4 open record of another tx
        {10'h030, 32'hC0DE_0030, 1'b0},   // R6 aborted record skipped
        {10'h040, 32'hC0DE_0040, 1'b0},   // R5 not in log
        {10'h000, 32'hC0DE_0000, 1'b0}    // R5 not in log
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] d;
        logic fl;
        int bad;
        for (int i = 0; i < (1 << ADDR_W); i++) nvm[i] = home(i);

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", "ap_ready",  ap_ready,  1);
        chk("R1", "cmd_ready", cmd_ready, 1);
        chk("R1", "rd_ready",  rd_ready,  1);
        chk("R1", "rd_valid",  rd_valid,  0);
        chk("R1", "rec_done",  rec_done,  0);
        chk("R1", "mem_we/re", {mem_we, mem_re}, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "ap_ready after release", ap_ready, 1);

        // build log: tx1 two versions, tx2, tx3 aborted (R2, R3)
        append(1, 'h010, 'h111);
        append(1, 'h010, 'h222);
        append(2, 'h020, 'h333);
        append(3, 'h030, 'h444);
        mark(3, 1);

        for (int v = 0; v < NV; v++) begin
            lookup(int'(VEC[v][ADDR_W+DATA_W:DATA_W+1]), d, fl);
            chk("R4/R5/R6", $sformatf("lookup data vec %0d", v), d, VEC[v][DATA_W:1]);
            chk("R4/R5/R6", $sformatf("lookup src vec %0d", v), fl, VEC[v][0]);
        end

        // R8: tx2 committed but tx1 open at head blocks copying
        mark(2, 0);
        repeat (20) @(negedge clk);
        chk("R8", "home 0x20 blocked", nvm['h020], home('h020));

        // R7/R6: abort tx1, copier drains
        mark(1, 1);
        repeat (30) @(negedge clk);
        chk("R7", "home 0x20 copied", nvm['h020], 32'h333);
        chk("R6", "home 0x10 untouched", nvm['h010], home('h010));
        chk("R6", "home 0x30 untouched", nvm['h030], home('h030));
        lookup('h020, d, fl);
        chk("R7", "0x20 served from home", {d[30:0], fl}, {31'h333, 1'b0});

        // R9: fill with DEPTH-1 data records of open tx5
        for (int i = 0; i < DEPTH - 1; i++) append(5, 'h100 + i, 'h5000 + i);
        @(negedge clk);
        ap_valid = 1; ap_txid = 6; ap_addr = 'h200; ap_data = 'h6000;
        bad = 0;
        for (int k = 0; k < 4; k++) begin #1; if (ap_ready) bad++; @(negedge clk); end
        chk("R9", "append refused at DEPTH-1", bad, 0);
        // mark still fits while the append waits (R3, R9)
        cmd_valid = 1; cmd_txid = 5; cmd_abort = 0;
        #1;
        chk("R9", "mark taken at DEPTH-1", cmd_ready, 1);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 0;
        #1;
        while (!ap_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        ap_valid = 0;
        repeat (120) @(negedge clk);
        bad = 0;
        for (int i = 0; i < DEPTH - 1; i++) if (nvm['h100 + i] !== DATA_W'('h5000 + i)) bad++;
        chk("R9", "all committed records copied home", bad, 0);
        chk("R8", "open tx6 not copied", nvm['h200], home('h200));

        // recovery set-up behind open tx6
        append(7, 'h300, 'h7001);
        append(7, 'h300, 'h7002);
        append(8, 'h310, 'h8001);
        mark(7, 0);
        mark(8, 1);
        append(9, 'h320, 'h9001);
        repeat (10) @(negedge clk);
        chk("R8", "tx7 held behind open tx6", nvm['h300], home('h300));

        // R12 during lookup
        @(negedge clk);
        rd_req = 1; rd_addr = 'h300;
        @(posedge clk);
        @(negedge clk);
        rd_req = 0;
        #1;
        chk("R12", "ap_ready during lookup", ap_ready, 0);
        chk("R12", "rd_ready during lookup", rd_ready, 0);
        while (!rd_valid) @(negedge clk);
        chk("R4", "lookup newest tx7", rd_data, 32'h7002);
        @(negedge clk);
        chk("R4", "rd_valid one cycle", rd_valid, 0);

        // R10/R11 recovery
        rec_start = 1;
        @(posedge clk);
        @(negedge clk);
        rec_start = 0;
        #1;
        chk("R12", "ap_ready during recovery", ap_ready, 0);
        chk("R12", "cmd_ready during recovery", cmd_ready, 0);
        while (!rec_done) @(negedge clk);
        @(negedge clk);
        chk("R10", "rec_done one cycle", rec_done, 0);
        chk("R10", "last committed version home", nvm['h300], 32'h7002);
        chk("R11", "unmarked tx6 skipped", nvm['h200], home('h200));
        chk("R11", "unmarked tx9 skipped", nvm['h320], home('h320));
        chk("R6", "aborted tx8 skipped", nvm['h310], home('h310));
        lookup('h320, d, fl);
        chk("R10", "log emptied, 0x320 from home", {d[30:0], fl}, {home('h320) & 32'h7FFF_FFFF, 1'b0} >> 0);
        lookup('h300, d, fl);
        chk("R10", "log emptied, 0x300 src", fl, 0);
        chk("R2", "append accepted after recovery", ap_ready, 1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule